// File: doc/BRIEF.md
# Guarded Multiplexed-Bus Memory Write Controller

This block sits between a microcontroller running a multiplexed address/data bus and an 8192-byte memory array that is organised as two independent 4096-byte banks. It captures the 13-bit address when the address strobe drops. The low byte comes from the shared bus and the upper five bits come from dedicated inputs. It then treats each rising edge of the enable input, while chip enable is high, as a data-phase strobe. The read/write input selects whether that strobe is a read or a write.

A write reaches the array only after a three-byte software unlock sequence, and only then if the target 1K region is unprotected and the hardware write-control input is high. Once the sequence has been accepted, it stays open for a group of writes and closes on the next read. A second three-byte sequence loads an eight-bit region protect mask from the byte that follows it.

Each accepted write marks its bank busy for a programmable number of clocks. A read of the busy bank returns a polling byte, while reads of the other bank pass through from the array. The array itself lives outside the block. The block drives its read address, write strobe, write address and write data, and it takes the array's read data back in.

Top module: `mbus_wr_guard`

## Requirements
- R1: The 13-bit address is stored on the first clock at which the address strobe is seen low after being high. Bits 7..0 are taken from the bus and bits 12..8 from the upper address inputs. That stored address is the one used by the following data strobe.
- R2: A write strobe is a clock where ce_i and en_i are high, en_i was low on the previous clock, and rw_i is 0. Writes of 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555 open the write window. A later permitted write produces mem_we_o high for exactly the one clock following its strobe, with the stored address and the bus byte.
- R3: A write with no open window produces no mem_we_o. A wrong byte or a wrong address at any step of a sequence returns the tracker to its idle state.
- R4: The window stays open across any number of writes. Any read strobe (rw_i = 1) closes it, and it also resets a partial sequence.
- R5: Writes of 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xC0 to 0x1555 arm a mask load. The byte of the next write strobe becomes the protect mask. Bit n protects the region where address bits 12..10 equal n. The tracker then returns to idle.
- R6: A write in the open window that targets a protected region produces no mem_we_o and does not set busy.
- R7: While wc_i is low, no write is committed and no mask load takes effect. Sequence tracking still advances.
- R8: A committed write sets busy_o[addr bit 12] from the clock after its strobe, for BUSY_CYC clocks.
- R9: While en_i, ce_i and rw_i are high, ad_oe_o is high. If the addressed bank is busy, ad_o bit 7 is the inverse of bit 7 of the data being written and bits 6..0 are 0. Otherwise ad_o equals mem_rdata_i.
- R10: A write in the open window to a bank that is still busy is dropped, and the window stays open.
- R11: After reset, mem_we_o and busy_o are 0, the protect mask is all zeros, and the tracker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe; address captured as it falls |
| ad_i | input | 8 | Shared bus: low address byte, then write data |
| addr_hi_i | input | 5 | Address bits 12..8 |
| en_i | input | 1 | Data-phase enable; rising edge is a strobe |
| rw_i | input | 1 | 1 read, 0 write |
| ce_i | input | 1 | Chip enable, active high |
| wc_i | input | 1 | Hardware write permit, active high |
| ad_o | output | 8 | Read data to the bus |
| ad_oe_o | output | 1 | Read data valid / drive enable |
| mem_rd_addr_o | output | 13 | Stored address to the array for reads |
| mem_rdata_i | input | 8 | Array read data |
| mem_we_o | output | 1 | Array write strobe, one clock |
| mem_wr_addr_o | output | 13 | Array write address |
| mem_wr_data_o | output | 8 | Array write data |
| busy_o | output | 2 | Per-bank busy flags |

## Verification
A committed write shows up on mem_we_o, mem_wr_addr_o and mem_wr_data_o one clock after the edge that samples its strobe. The bench therefore reads these outputs at the falling edge right after that strobe edge. busy_o rises on that same edge and falls BUSY_CYC edges later. The bench models busy as a window of edge counts and compares busy_o at every write check. Read data is combinational while en_i is high, so it is sampled a quarter period after the inputs change and before the strobe edge closes the window.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_OPEN,
    ST_MASK
  } seq_t;

  localparam logic [12:0] KEY_ADDR_A = 13'h1555;
  localparam logic [12:0] KEY_ADDR_B = 13'h0AAA;
  localparam logic [7:0]  KEY_BYTE1  = 8'hAA;
  localparam logic [7:0]  KEY_BYTE2  = 8'h55;
  localparam logic [7:0]  CMD_WRITE  = 8'hA0;
  localparam logic [7:0]  CMD_MASK   = 8'hC0;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 13,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              en_i,
  input  logic              rw_i,
  input  logic              ce_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic              rd_stb_o
);
  logic as_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q   <= 1'b0;
      en_q   <= 1'b0;
      addr_o <= '0;
    end else begin
      as_q <= as_i;
      en_q <= en_i;
      if (as_q && !as_i) addr_o <= {addr_hi_i, ad_i};
    end
  end

  logic stb;
  assign stb      = ce_i & en_i & ~en_q;
  assign wr_stb_o = stb & ~rw_i;
  assign rd_stb_o = stb & rw_i;
endmodule

// File: rtl/mbus_seq_guard.sv
module mbus_seq_guard
  import mbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 13,
  parameter int BANKS   = 2,
  parameter int REGIONS = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int REG_W  = $clog2(REGIONS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic               rd_stb_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               wc_i,
  input  logic [BANKS-1:0]   busy_i,
  output logic               commit_o,
  output logic [REGIONS-1:0] mask_o
);
  seq_t st_q, st_d;
  logic mask_we;

  logic [REG_W-1:0]  region;
  logic [BANK_W-1:0] bank;
  assign region = addr_i[ADDR_W-1 -: REG_W];
  assign bank   = addr_i[ADDR_W-1 -: BANK_W];

  logic at_a, at_b;
  assign at_a = (addr_i == ADDR_W'(KEY_ADDR_A));
  assign at_b = (addr_i == ADDR_W'(KEY_ADDR_B));

  always_comb begin
    st_d     = st_q;
    commit_o = 1'b0;
    mask_we  = 1'b0;
    if (rd_stb_i) begin
      st_d = ST_IDLE;
    end else if (wr_stb_i) begin
      case (st_q)
        ST_IDLE: st_d = (at_a && data_i == DATA_W'(KEY_BYTE1)) ? ST_KEY1 : ST_IDLE;
        ST_KEY1: st_d = (at_b && data_i == DATA_W'(KEY_BYTE2)) ? ST_KEY2 : ST_IDLE;
        ST_KEY2: begin
          if (at_a && data_i == DATA_W'(CMD_WRITE))     st_d = ST_OPEN;
          else if (at_a && data_i == DATA_W'(CMD_MASK)) st_d = ST_MASK;
          else                                          st_d = ST_IDLE;
        end
        ST_OPEN: commit_o = wc_i & ~mask_o[region] & ~busy_i[bank];
        ST_MASK: begin
          mask_we = wc_i;
          st_d    = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_o <= '0;
    end else begin
      st_q <= st_d;
      if (mask_we) mask_o <= data_i[REGIONS-1:0];
    end
  end
endmodule

// File: rtl/mbus_bank_busy.sv
module mbus_bank_busy #(
  parameter int BANKS    = 2,
  parameter int BUSY_CYC = 16,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              msb_i,
  output logic [BANKS-1:0]  busy_o,
  output logic [BANKS-1:0]  poll_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q     <= '0;
        poll_o[b] <= 1'b0;
      end else if (start_i && bank_i == BANK_W'(b)) begin
        cnt_q     <= CNT_W'(BUSY_CYC);
        poll_o[b] <= ~msb_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/mbus_wr_guard.sv
module mbus_wr_guard #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 13,
  parameter int BANKS    = 2,
  parameter int REGIONS  = 8,
  parameter int BUSY_CYC = 16,
  localparam int HI_W    = ADDR_W - DATA_W,
  localparam int BANK_W  = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              en_i,
  input  logic              rw_i,
  input  logic              ce_i,
  input  logic              wc_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic [BANKS-1:0]  busy_o
);
  logic [ADDR_W-1:0]  lat_addr;
  logic               wr_stb, rd_stb, commit;
  logic [REGIONS-1:0] prot_mask;
  logic [BANKS-1:0]   poll_bit;
  logic [BANK_W-1:0]  lat_bank;

  assign lat_bank = lat_addr[ADDR_W-1 -: BANK_W];

  mbus_addr_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_latch (
    .clk_i, .rst_ni, .as_i, .ad_i, .addr_hi_i, .en_i, .rw_i, .ce_i,
    .addr_o(lat_addr), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  mbus_seq_guard #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANKS(BANKS), .REGIONS(REGIONS)
  ) u_seq (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .rd_stb_i(rd_stb), .addr_i(lat_addr),
    .data_i(ad_i), .wc_i, .busy_i(busy_o), .commit_o(commit), .mask_o(prot_mask)
  );

  mbus_bank_busy #(.BANKS(BANKS), .BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni, .start_i(commit), .bank_i(lat_bank),
    .msb_i(ad_i[DATA_W-1]), .busy_o, .poll_o(poll_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o      <= 1'b0;
      mem_wr_addr_o <= '0;
      mem_wr_data_o <= '0;
    end else begin
      mem_we_o <= commit;
      if (commit) begin
        mem_wr_addr_o <= lat_addr;
        mem_wr_data_o <= ad_i;
      end
    end
  end

  assign mem_rd_addr_o = lat_addr;
  assign ad_oe_o       = ce_i & en_i & rw_i;
  assign ad_o          = busy_o[lat_bank] ? {poll_bit[lat_bank], {(DATA_W-1){1'b0}}}
                                          : mem_rdata_i;
endmodule

// File: rtl/mbus_wr_guard_chk.sv
module mbus_wr_guard_chk #(
  parameter int ADDR_W  = 13,
  parameter int BANKS   = 2,
  parameter int REGIONS = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int REG_W  = $clog2(REGIONS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wc_i,
  input logic               mem_we_o,
  input logic [ADDR_W-1:0]  mem_wr_addr_o,
  input logic [BANKS-1:0]   busy_o,
  input logic [REGIONS-1:0] prot_mask
);
  logic [BANKS-1:0] busy_q;
  logic [BANK_W-1:0] wb;
  assign wb = mem_wr_addr_o[ADDR_W-1 -: BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_o;
  end

  p_commit_needs_wc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(wc_i));

  p_commit_unprotected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !prot_mask[mem_wr_addr_o[ADDR_W-1 -: REG_W]]);

  p_commit_sets_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o[wb]);

  p_no_write_busy_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !busy_q[wb]);

  for (genvar b = 0; b < BANKS; b++) begin : g_rise
    p_busy_rise_from_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[b] && !busy_q[b]) |-> (mem_we_o && wb == BANK_W'(b)));
  end
endmodule

bind mbus_wr_guard mbus_wr_guard_chk #(
  .ADDR_W(ADDR_W), .BANKS(BANKS), .REGIONS(REGIONS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wc_i(wc_i), .mem_we_o(mem_we_o),
  .mem_wr_addr_o(mem_wr_addr_o), .busy_o(busy_o), .prot_mask(prot_mask)
);

// File: tb/sim_mbus_wr_guard.sv
module sim_mbus_wr_guard;
  localparam int CLK_P = 10;
  localparam int BUSY  = 16;

  logic clk = 0, rst_n = 0;
  logic as_s = 0, en_s = 0, rw_s = 0, ce_s = 1, wc_s = 1;
  logic [7:0] ad_s = 0;
  logic [4:0] hi_s = 0;
  logic [7:0] ad_o, mem_rdata, wdat;
  logic ad_oe, we;
  logic [12:0] rd_addr, waddr;
  logic [1:0] busy;

  always #(CLK_P/2) clk = ~clk;

  mbus_wr_guard #(.BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .as_i(as_s), .ad_i(ad_s), .addr_hi_i(hi_s),
    .en_i(en_s), .rw_i(rw_s), .ce_i(ce_s), .wc_i(wc_s), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .mem_rd_addr_o(rd_addr), .mem_rdata_i(mem_rdata), .mem_we_o(we),
    .mem_wr_addr_o(waddr), .mem_wr_data_o(wdat), .busy_o(busy)
  );

  function automatic logic [7:0] arr_val(input logic [12:0] a);
    return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h3C;
  endfunction
  assign mem_rdata = arr_val(rd_addr);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state: 0 idle,1 key1,2 key2,3 open,4 mask armed
  int m_st = 0;
  logic [7:0] m_mask = 0;
  int m_until[2] = '{0, 0};
  logic m_poll[2] = '{0, 0};

  function automatic bit m_busy(input int b);
    return cyc < m_until[b];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic addr_phase(input logic [12:0] a);
    @(negedge clk); as_s = 1; ad_s = a[7:0]; hi_s = a[12:8];
    @(negedge clk); as_s = 0;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d, input string req);
    bit exp_we = 0;
    int b = a[12];
    addr_phase(a);
    @(negedge clk); ad_s = d; rw_s = 0; en_s = 1;
    case (m_st)
      0: m_st = (a == 13'h1555 && d == 8'hAA) ? 1 : 0;
      1: m_st = (a == 13'h0AAA && d == 8'h55) ? 2 : 0;
      2: m_st = (a == 13'h1555 && d == 8'hA0) ? 3 : (a == 13'h1555 && d == 8'hC0) ? 4 : 0;
      3: exp_we = wc_s && !m_mask[a[12:10]] && !m_busy(b);
      default: begin if (wc_s) m_mask = d; m_st = 0; end
    endcase
    if (exp_we) begin
      m_until[b] = cyc + 1 + BUSY;
      m_poll[b]  = ~d[7];
    end
    @(negedge clk); en_s = 0;
    chk(we == exp_we, req, we, exp_we);
    if (exp_we) begin
      chk(waddr == a, "R1", waddr, a);
      chk(wdat == d, "R2", wdat, d);
    end
    chk(busy == {m_busy(1), m_busy(0)}, "R8", busy, {m_busy(1), m_busy(0)});
  endtask

  task automatic do_read(input logic [12:0] a, input string req);
    logic [7:0] exp;
    addr_phase(a);
    @(negedge clk); rw_s = 1; en_s = 1;
    #(CLK_P/4);
    exp = m_busy(a[12]) ? {m_poll[a[12]], 7'b0} : arr_val(a);
    chk(ad_oe == 1'b1, "R9", ad_oe, 1);
    chk(ad_o == exp, req, ad_o, exp);
    @(negedge clk); en_s = 0; rw_s = 0;
    m_st = 0;
  endtask

  task automatic unlock(input string req);
    do_write(13'h1555, 8'hAA, req);
    do_write(13'h0AAA, 8'h55, req);
    do_write(13'h1555, 8'hA0, req);
  endtask

  task automatic load_mask(input logic [7:0] m, input string req);
    do_write(13'h1555, 8'hAA, req);
    do_write(13'h0AAA, 8'h55, req);
    do_write(13'h1555, 8'hC0, req);
    do_write($urandom() & 13'h1FFF, m, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #(CLK_P * 3);
    @(negedge clk);
    chk(we == 0 && busy == 0, "R11", {we, busy}, 0);
    chk(ad_oe == 0, "R11", ad_oe, 0);
    rst_n = 1;
    @(negedge clk);
    chk(we == 0 && busy == 0, "R11", {we, busy}, 0);

    // R3: no window yet
    do_write(13'h0123, 8'h77, "R3");
    // R2 / R11: unlock, mask clear so region 7 accepts
    unlock("R2");
    do_write(13'h1F00, 8'h81, "R11");
    // R4: window persists, other bank while bank1 busy
    do_write(13'h0010, 8'h12, "R4");
    // R10: bank0 busy, dropped
    do_write(13'h0020, 8'h34, "R10");
    // R9: poll on busy banks
    do_read(13'h1F00, "R9");
    idle(BUSY + 2);
    do_read(13'h0456, "R9");
    // R4: read closed the window
    do_write(13'h0200, 8'h55, "R4");
    // R3: wrong address at step two
    do_write(13'h1555, 8'hAA, "R3");
    do_write(13'h0AAB, 8'h55, "R3");
    do_write(13'h1555, 8'hA0, "R3");
    do_write(13'h0300, 8'h66, "R3");
    // R5/R6: protect regions 0 and 2
    load_mask(8'h05, "R5");
    unlock("R6");
    do_write(13'h0800, 8'h99, "R6");
    do_write(13'h0400, 8'h5A, "R5");
    idle(BUSY + 2);
    // R7: wc low blocks write and mask load
    wc_s = 0;
    do_write(13'h1000, 8'h01, "R7");
    load_mask(8'hFF, "R7");
    wc_s = 1;
    unlock("R7");
    do_write(13'h1C00, 8'hC3, "R7");
    idle(BUSY + 2);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 99);
      wc_s = ($urandom_range(0, 99) < 88);
      if (op < 30) begin
        unlock("R2");
        for (int k = 0; k < int'($urandom_range(1, 3)); k++)
          do_write($urandom() & 13'h1FFF, $urandom() & 8'hFF, "R2");
      end else if (op < 38) begin
        load_mask(8'h1 << $urandom_range(0, 7) | (($urandom_range(0, 3) == 0) ? 8'hF0 : 8'h00), "R5");
      end else if (op < 58) begin
        do_read($urandom() & 13'h1FFF, "R9");
      end else if (op < 75) begin
        do_write(($urandom_range(0, 1) != 0) ? 13'h1555 : ($urandom() & 13'h1FFF),
                 ($urandom_range(0, 1) != 0) ? 8'hAA : ($urandom() & 8'hFF), "R3");
      end else if (op < 85) begin
        do_write(13'h1555, 8'hAA, "R3");
        do_write(13'h0AAA, ($urandom_range(0, 1) != 0) ? 8'h54 : 8'h55, "R3");
        do_write($urandom() & 13'h1FFF, 8'hA0, "R3");
      end else begin
        idle($urandom_range(1, BUSY));
      end
    end
    wc_s = 1;
    idle(4);
    finish_run();
  end
endmodule